// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

An eight-pin general-purpose I/O port whose pins can each be taken over by an enabled on-chip peripheral. Software programs a direction bit and an output latch bit for every pin. A pin claimed by a CAN channel, by a CAN channel moved onto alternate pins, or by a routed SPI gets a forced direction. When the peripheral drives the pin as an output, the peripheral also supplies the pad value. The stored direction bit stays as software wrote it, so the pin goes back to software control as soon as the peripheral lets go.

Pad levels reach the register bus through a two-flop synchronizer. A read of the pin level therefore trails the pad by two clocks, and it can trail a change of direction by the same amount. Bus reads are combinational on the address. Writes take effect at the clock edge that samples them. The reset input is asynchronous and active low, and the reset tree releases it synchronously to the clock.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is held and after its release, the direction register and the output latch read 0. With no peripheral enabled, every `pad_oe` and `pad_out` bit is then 0.
- R2: A pin with no peripheral claiming it has `pad_oe` equal to its direction bit, where 1 means output, and `pad_out` equal to its latch bit. Pins 5 to 7 are always under software control.
- R3: When `can_a_en` is 1 and `can_a_route` is 0, pin 0 is an input and pin 1 is an output that drives `can_a_tx`.
- R4: Pin 2 is forced to input and pin 3 is forced to output in either of two cases. When `can_b_en` is 1, pin 3 drives `can_b_tx`. When `can_a_en` is 1 and `can_a_route` is 1, pin 3 drives `can_a_tx`.
- R5: Pin 4 is forced to input in any of three cases: `can_c_en` is 1, `can_e_en` is 1, or `can_a_en` is 1 with `can_a_route` equal to 2. With `can_a_route` equal to 2, pins 0 to 3 are not claimed by channel A.
- R6: When `spi_rt_en` is 1, pins 2, 3 and 4 take their direction from `spi_dir` bits 0, 1 and 2, where 1 means output. An output pin drives the matching `spi_out` bit.
- R7: When several sources claim a pin, one source wins in this order: the channel native to the pin (A on pins 0 and 1, B on pins 2 and 3, C on pin 4), then a moved CAN channel, then the routed SPI, then the software bit. A pin forced to input shows its latch bit on `pad_out`.
- R8: A peripheral override never changes the direction register. When the peripheral is disabled, `pad_oe` follows the stored bit again.
- R9: The input register at address 2 returns the pad level as it was two rising clock edges earlier.
- R10: The data register at address 0 returns the latch bit for pins whose effective direction is output, and the synchronized pad level for pins whose effective direction is input.
- R11: Address 1 holds the direction register. Writes to address 2 or 3 change nothing. A read of address 3, or any read with `bus_sel` or `bus_wr` set wrongly, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW (2) | Register address |
| bus_wdata | input | NPINS (8) | Write data |
| bus_rdata | output | NPINS (8) | Read data, combinational |
| can_a_en | input | 1 | CAN channel A enabled |
| can_a_route | input | 2 | Pins used by channel A: 0 = pins 0/1, 1 = pins 2/3, 2 = pin 4, 3 = none |
| can_a_tx | input | 1 | Channel A transmit value |
| can_b_en | input | 1 | CAN channel B enabled |
| can_b_tx | input | 1 | Channel B transmit value |
| can_c_en | input | 1 | CAN channel C enabled (pin 4 receive) |
| can_e_en | input | 1 | CAN channel E enabled and moved onto pin 4 |
| spi_rt_en | input | 1 | Routed SPI enabled on pins 2 to 4 |
| spi_dir | input | 3 | SPI direction for pins 2 to 4, 1 = output |
| spi_out | input | 3 | SPI output values for pins 2 to 4 |
| pad_in | input | NPINS (8) | Pad input levels |
| pad_out | output | NPINS (8) | Pad output values |
| pad_oe | output | NPINS (8) | Pad output enables |

## Verification
Two things can happen in the same cycle: an override that changes a pin's effective direction, and a data-register read of that pin. In that cycle the data read switches between the latch and the synchronized pad level. The bench provokes this by holding the pad and the latch at different values and enabling CAN channel A between two reads of the data register. The pin-0 bit must move from the latch value to the pad value with no bus write in between. The bench then reads the direction register while channel A still owns the pins, and checks that the stored direction was left alone.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  // Who controls a pin after arbitration; higher code wins.
  typedef enum logic [1:0] {
    OWN_SW   = 2'd0,
    OWN_SPI  = 2'd1,
    OWN_RCAN = 2'd2,
    OWN_NAT  = 2'd3
  } own_e;

  // Register map.
  localparam int ADDR_DATA = 0;
  localparam int ADDR_DIR  = 1;
  localparam int ADDR_INP  = 2;

  // Placements of CAN channel A.
  localparam logic [1:0] CANA_HOME = 2'd0;
  localparam logic [1:0] CANA_MID  = 2'd1;
  localparam logic [1:0] CANA_HI   = 2'd2;

  // Pin assignment of the peripherals.
  localparam int PIN_LO_RX  = 0;
  localparam int PIN_LO_TX  = 1;
  localparam int PIN_MID_RX = 2;
  localparam int PIN_MID_TX = 3;
  localparam int PIN_HI_RX  = 4;
  localparam int SPI_BASE   = 2;
  localparam int SPI_PINS   = 3;
  localparam int MIN_PINS   = 5;

endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_ovr_claims.sv
module gpio_ovr_claims
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                can_a_en,
  input  logic [1:0]          can_a_route,
  input  logic                can_a_tx,
  input  logic                can_b_en,
  input  logic                can_b_tx,
  input  logic                can_c_en,
  input  logic                can_e_en,
  input  logic                spi_rt_en,
  input  logic [SPI_PINS-1:0] spi_dir,
  input  logic [SPI_PINS-1:0] spi_out,
  output logic [NPINS-1:0]    nat_claim,
  output logic [NPINS-1:0]    nat_oe,
  output logic [NPINS-1:0]    nat_out,
  output logic [NPINS-1:0]    rc_claim,
  output logic [NPINS-1:0]    rc_oe,
  output logic [NPINS-1:0]    rc_out,
  output logic [NPINS-1:0]    spi_claim,
  output logic [NPINS-1:0]    spi_oe,
  output logic [NPINS-1:0]    spi_val
);

  logic a_home, a_mid, a_hi;

  assign a_home = can_a_en && (can_a_route == CANA_HOME);
  assign a_mid  = can_a_en && (can_a_route == CANA_MID);
  assign a_hi   = can_a_en && (can_a_route == CANA_HI);

  // Native owners: channel A on its home pins, B in the middle, C on the high pin.
  always_comb begin
    nat_claim = '0;
    nat_oe    = '0;
    nat_out   = '0;
    nat_claim[PIN_LO_RX]  = a_home;
    nat_claim[PIN_LO_TX]  = a_home;
    nat_oe[PIN_LO_TX]     = 1'b1;
    nat_out[PIN_LO_TX]    = can_a_tx;
    nat_claim[PIN_MID_RX] = can_b_en;
    nat_claim[PIN_MID_TX] = can_b_en;
    nat_oe[PIN_MID_TX]    = 1'b1;
    nat_out[PIN_MID_TX]   = can_b_tx;
    nat_claim[PIN_HI_RX]  = can_c_en;
  end

  // Moved CAN channels.
  always_comb begin
    rc_claim = '0;
    rc_oe    = '0;
    rc_out   = '0;
    rc_claim[PIN_MID_RX] = a_mid;
    rc_claim[PIN_MID_TX] = a_mid;
    rc_oe[PIN_MID_TX]    = 1'b1;
    rc_out[PIN_MID_TX]   = can_a_tx;
    rc_claim[PIN_HI_RX]  = a_hi || can_e_en;
  end

  // Routed SPI over a contiguous pin window.
  always_comb begin
    spi_claim = '0;
    spi_oe    = '0;
    spi_val   = '0;
    for (int k = 0; k < SPI_PINS; k++) begin
      spi_claim[SPI_BASE+k] = spi_rt_en;
      spi_oe[SPI_BASE+k]    = spi_dir[k];
      spi_val[SPI_BASE+k]   = spi_out[k];
    end
  end

endmodule

// File: rtl/gpio_ovr_arbiter.sv
module gpio_ovr_arbiter
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] nat_claim,
  input  logic [NPINS-1:0] nat_oe,
  input  logic [NPINS-1:0] nat_out,
  input  logic [NPINS-1:0] rc_claim,
  input  logic [NPINS-1:0] rc_oe,
  input  logic [NPINS-1:0] rc_out,
  input  logic [NPINS-1:0] spi_claim,
  input  logic [NPINS-1:0] spi_oe,
  input  logic [NPINS-1:0] spi_val,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] lat_q,
  output logic [NPINS-1:0] eff_oe,
  output logic [NPINS-1:0] eff_out
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    own_e own;
    logic oe_b;
    logic out_b;

    always_comb begin
      if (nat_claim[g])      own = OWN_NAT;
      else if (rc_claim[g])  own = OWN_RCAN;
      else if (spi_claim[g]) own = OWN_SPI;
      else                   own = OWN_SW;
    end

    always_comb begin
      case (own)
        OWN_NAT: begin
          oe_b  = nat_oe[g];
          out_b = nat_oe[g] ? nat_out[g] : lat_q[g];
        end
        OWN_RCAN: begin
          oe_b  = rc_oe[g];
          out_b = rc_oe[g] ? rc_out[g] : lat_q[g];
        end
        OWN_SPI: begin
          oe_b  = spi_oe[g];
          out_b = spi_oe[g] ? spi_val[g] : lat_q[g];
        end
        default: begin
          oe_b  = dir_q[g];
          out_b = lat_q[g];
        end
      endcase
    end

    assign eff_oe[g]  = oe_b;
    assign eff_out[g] = out_b;
  end

endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic [NPINS-1:0] eff_oe,
  input  logic [NPINS-1:0] in_sync,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lat_q,
  output logic [NPINS-1:0] bus_rdata
);

  localparam logic [AW-1:0] A_DATA = AW'(ADDR_DATA);
  localparam logic [AW-1:0] A_DIR  = AW'(ADDR_DIR);
  localparam logic [AW-1:0] A_INP  = AW'(ADDR_INP);

  logic             dir_en, lat_en, rd_en;
  logic [NPINS-1:0] dir_d, lat_d;

  assign dir_en = bus_sel && bus_wr && (bus_addr == A_DIR);
  assign lat_en = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign rd_en  = bus_sel && !bus_wr;

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (dir_en) dir_d = bus_wdata;
    if (lat_en) lat_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      dir_q <= dir_d;
      lat_q <= lat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == A_DATA)     bus_rdata = (lat_q & eff_oe) | (in_sync & ~eff_oe);
      else if (bus_addr == A_DIR) bus_rdata = dir_q;
      else if (bus_addr == A_INP) bus_rdata = in_sync;
    end
  end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [NPINS-1:0]    bus_wdata,
  output logic [NPINS-1:0]    bus_rdata,
  input  logic                can_a_en,
  input  logic [1:0]          can_a_route,
  input  logic                can_a_tx,
  input  logic                can_b_en,
  input  logic                can_b_tx,
  input  logic                can_c_en,
  input  logic                can_e_en,
  input  logic                spi_rt_en,
  input  logic [SPI_PINS-1:0] spi_dir,
  input  logic [SPI_PINS-1:0] spi_out,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe
);

  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] dir_q, lat_q, in_sync;
  logic [NPINS-1:0] nat_claim, nat_oe, nat_out;
  logic [NPINS-1:0] rc_claim, rc_oe, rc_out;
  logic [NPINS-1:0] spi_claim, spi_oe, spi_val;
  logic [NPINS-1:0] eff_oe, eff_out;

  gpio_ovr_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  gpio_ovr_claims #(.NPINS(NPINS)) u_claims (
    .can_a_en    (can_a_en),
    .can_a_route (can_a_route),
    .can_a_tx    (can_a_tx),
    .can_b_en    (can_b_en),
    .can_b_tx    (can_b_tx),
    .can_c_en    (can_c_en),
    .can_e_en    (can_e_en),
    .spi_rt_en   (spi_rt_en),
    .spi_dir     (spi_dir),
    .spi_out     (spi_out),
    .nat_claim   (nat_claim),
    .nat_oe      (nat_oe),
    .nat_out     (nat_out),
    .rc_claim    (rc_claim),
    .rc_oe       (rc_oe),
    .rc_out      (rc_out),
    .spi_claim   (spi_claim),
    .spi_oe      (spi_oe),
    .spi_val     (spi_val)
  );

  gpio_ovr_arbiter #(.NPINS(NPINS)) u_arb (
    .nat_claim (nat_claim),
    .nat_oe    (nat_oe),
    .nat_out   (nat_out),
    .rc_claim  (rc_claim),
    .rc_oe     (rc_oe),
    .rc_out    (rc_out),
    .spi_claim (spi_claim),
    .spi_oe    (spi_oe),
    .spi_val   (spi_val),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .eff_oe    (eff_oe),
    .eff_out   (eff_out)
  );

  gpio_ovr_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .eff_oe    (eff_oe),
    .in_sync   (in_sync),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .bus_rdata (bus_rdata)
  );

  assign pad_oe  = eff_oe;
  assign pad_out = eff_out;

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic             can_a_en,
  input logic [1:0]       can_a_route,
  input logic             can_a_tx,
  input logic             can_b_en,
  input logic             can_b_tx,
  input logic             can_c_en,
  input logic             can_e_en,
  input logic             spi_rt_en,
  input logic [2:0]       spi_dir,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] lat_q,
  input logic [NPINS-1:0] in_sync
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_SW_HIGH_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[NPINS-1:5] == dir_q[NPINS-1:5]) && (pad_out[NPINS-1:5] == lat_q[NPINS-1:5])); // R2

  AST_CANA_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (can_a_en && can_a_route == 2'd0) |-> (!pad_oe[0] && pad_oe[1] && pad_out[1] == can_a_tx)); // R3

  AST_CANB_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    can_b_en |-> (!pad_oe[2] && pad_oe[3] && pad_out[3] == can_b_tx)); // R4

  AST_HI_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (can_c_en || can_e_en || (can_a_en && can_a_route == 2'd2)) |-> !pad_oe[4]); // R5

  AST_SPI_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_rt_en && !can_b_en && !(can_a_en && can_a_route == 2'd1)) |-> (pad_oe[2] == spi_dir[0])); // R6

  AST_NATIVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (can_b_en && can_a_en && can_a_route == 2'd1) |-> (pad_out[3] == can_b_tx)); // R7

  AST_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == AW'(1)) |=> $stable(dir_q)); // R8

  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (in_sync == $past(pad_in, 2))); // R9

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .can_a_en    (can_a_en),
  .can_a_route (can_a_route),
  .can_a_tx    (can_a_tx),
  .can_b_en    (can_b_en),
  .can_b_tx    (can_b_tx),
  .can_c_en    (can_c_en),
  .can_e_en    (can_e_en),
  .spi_rt_en   (spi_rt_en),
  .spi_dir     (spi_dir),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .dir_q       (dir_q),
  .lat_q       (lat_q),
  .in_sync     (in_sync)
);

// File: tb/gpio_ovr_port_tb_top.sv
module gpio_ovr_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] dat;
    logic       a_en;
    logic [1:0] a_rt;
    logic       a_tx;
    logic       b_en;
    logic       b_tx;
    logic       c_en;
    logic       e_en;
    logic       s_en;
    logic [2:0] s_dir;
    logic [2:0] s_out;
    logic [7:0] oe;
    logic [7:0] out;
  } vec_t;

  // dir, dat, a_en, a_rt, a_tx, b_en, b_tx, c_en, e_en, s_en, s_dir, s_out, exp oe, exp out
  localparam vec_t VECS [NV] = '{
    '{8'hF0, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'hF0, 8'hAA}, // R2
    '{8'h00, 8'h00, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'h02, 8'h02}, // R3
    '{8'hFF, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'hFE, 8'h00}, // R3
    '{8'h00, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'h08, 8'hF7}, // R4
    '{8'hFF, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'hFB, 8'h08}, // R4
    '{8'hFF, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 8'hEF, 8'h00}, // R5
    '{8'hFF, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 8'hEF, 8'h00}, // R5
    '{8'hFF, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'hEF, 8'h00}, // R5
    '{8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101, 3'b111, 8'h14, 8'h14}, // R6
    '{8'h00, 8'h00, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 8'h08, 8'h08}, // R7
    '{8'h00, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101, 3'b000, 8'h18, 8'h08}, // R7
    '{8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'b100, 3'b100, 8'h00, 8'h00}  // R7
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       can_a_en, can_a_tx, can_b_en, can_b_tx, can_c_en, can_e_en, spi_rt_en;
  logic [1:0] can_a_route;
  logic [2:0] spi_dir, spi_out;
  logic [7:0] pad_in, pad_out, pad_oe;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .can_a_en(can_a_en), .can_a_route(can_a_route),
    .can_a_tx(can_a_tx), .can_b_en(can_b_en), .can_b_tx(can_b_tx), .can_c_en(can_c_en),
    .can_e_en(can_e_en), .spi_rt_en(spi_rt_en), .spi_dir(spi_dir), .spi_out(spi_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4:    return "R4";
      5, 6, 7: return "R5";
      8:       return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic periph_off();
    can_a_en = 1'b0; can_a_route = 2'd0; can_a_tx = 1'b0;
    can_b_en = 1'b0; can_b_tx = 1'b0; can_c_en = 1'b0; can_e_en = 1'b0;
    spi_rt_en = 1'b0; spi_dir = 3'b000; spi_out = 3'b000;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pad_in = 8'h00;
    periph_off();
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    bus_read(2'd1, rd);
    check("R1 dir after reset", rd, 8'h00);
    check("R1 out after reset", pad_out, 8'h00);

    // Vector table: R2..R7
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd1, VECS[i].dir);
      bus_write(2'd0, VECS[i].dat);
      @(negedge clk);
      can_a_en = VECS[i].a_en; can_a_route = VECS[i].a_rt; can_a_tx = VECS[i].a_tx;
      can_b_en = VECS[i].b_en; can_b_tx = VECS[i].b_tx;
      can_c_en = VECS[i].c_en; can_e_en = VECS[i].e_en;
      spi_rt_en = VECS[i].s_en; spi_dir = VECS[i].s_dir; spi_out = VECS[i].s_out;
      #1;
      check({vec_req(i), " oe"}, pad_oe, VECS[i].oe);
      check({vec_req(i), " out"}, pad_out, VECS[i].out);
      periph_off();
    end

    // R8: override leaves the stored direction alone and releases back to it
    bus_write(2'd1, 8'hFF);
    @(negedge clk);
    can_a_en = 1'b1; can_b_en = 1'b1; can_c_en = 1'b1;
    bus_read(2'd1, rd);
    check("R8 dir kept", rd, 8'hFF);
    @(negedge clk);
    periph_off();
    #1 check("R8 revert", pad_oe, 8'hFF);

    // R9: two-edge lag on the input register
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
    pad_in = 8'h5A;
    @(negedge clk);
    #1 check("R9 one edge", bus_rdata, 8'h00);
    @(negedge clk);
    #1 check("R9 two edges", bus_rdata, 8'h5A);
    bus_sel = 1'b0;

    // R10: data read mixes latch and pad, switching with the override
    pad_in = 8'hC5;
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'h32);
    repeat (2) @(negedge clk);
    bus_read(2'd0, rd);
    check("R10 sw mix", rd, 8'hC2);
    can_a_en = 1'b1;
    bus_read(2'd0, rd);
    check("R10 override mix", rd, 8'hC3);
    bus_read(2'd1, rd);
    check("R8 dir under override", rd, 8'h0F);
    periph_off();

    // R11: read-only and unused addresses
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd2, rd);
    check("R11 input ro", rd, 8'hC5);
    bus_read(2'd3, rd);
    check("R11 unused", rd, 8'h00);
    bus_read(2'd1, rd);
    check("R11 dir untouched", rd, 8'h0F);
    bus_read(2'd0, rd);
    check("R11 latch untouched", rd, 8'hC2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1;
    #1 check("R11 no read on write", bus_rdata, 8'h00);
    bus_sel = 1'b0; bus_wr = 1'b0;

    // R1: asynchronous reset mid-run clears the registers
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async clear", pad_oe, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(2'd0, rd);
    check("R1 latch cleared", pad_out, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule